// File: doc/BRIEF.md
# Dual Wiper Code Register Bank

This block sits behind a serial bus engine and holds the state of two digitally set potentiometer channels. Each channel has a volatile wiper code, which drives the channel's tap select, and a non-volatile start-up value. The bank also holds five general-purpose non-volatile bytes, one reserved byte, and a volatile mode byte at address 8. The mode byte decides whether addresses 0 and 1 reach the wiper codes alone or the stored start-up values as well.

The bus engine presents each received data byte as a write beat on a valid/ready channel. A beat is taken only on a cycle where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low the engine must hold the beat or drop it; the bank never takes a beat while it is busy. Reads are combinational: `rd_data` follows `rd_addr` in the same cycle.

A write to a non-volatile location is not committed at once. It is held until the engine reports the bus STOP on `stop_evt`. A timed busy cycle then runs, and the stored byte changes when that cycle ends. After reset the block runs a recall window: the wiper codes sit at mid-scale, then they are loaded from the stored start-up values. Both delays are parameters counted in clock cycles.

Top module: `wiper_bank`

## Requirements
- R1: While reset is held, and during the recall window that follows it, both wiper outputs read 80h, `busy` is high and `wr_ready` is low.
- R2: `busy` stays high for exactly RECALL_CYC cycles after reset is released. In the cycle it falls, wiper 0 and wiper 1 take the start-up values stored at addresses 0 and 1.
- R3: With mode byte 00h, a read of address 0 or 1 returns the stored start-up value. A write to address 0 or 1 changes that channel's wiper output on the cycle after the beat is taken. The stored value changes only after the next commit.
- R4: With mode byte 80h, a read of address 0 or 1 returns the wiper code. A write to address 0 or 1 changes only the wiper code and leaves the stored value as it was.
- R5: Addresses 2 to 6 are written and read as stored bytes only while the mode byte is 00h. While the mode byte is 80h, writes to them are discarded and reads return 00h.
- R6: A STOP pulse that follows an accepted non-volatile write (address 0 to 6, mode 00h) holds `busy` high for exactly NV_CYC cycles. The stored byte shows the new value once `busy` falls.
- R7: A STOP with no pending non-volatile write starts no busy cycle. This covers a STOP after a mode-80h write, after a write to address 8, after a discarded write, or after reads alone.
- R8: A write to address 8 takes effect only for the values 00h and 80h; any other value leaves the mode byte unchanged. A read of address 8 returns the mode byte.
- R9: Writes to address 7 are discarded. Reads of address 7, or of any address above 8, return 00h.
- R10: While `busy` is high, `wr_ready` is low, a presented write beat has no effect, and a STOP pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts the recall window |
| wr_valid | input | 1 | Write beat offered by the bus engine |
| wr_ready | output | 1 | Bank can take a write beat (low while busy) |
| wr_addr | input | ADDR_W | Register address of the write beat |
| wr_data | input | DATA_W | Data byte of the write beat |
| rd_addr | input | ADDR_W | Register address for the combinational read |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| stop_evt | input | 1 | One-cycle pulse marking a bus STOP |
| busy | output | 1 | Recall window or non-volatile commit in progress |
| wiper0 | output | DATA_W | Wiper code of channel 0 |
| wiper1 | output | DATA_W | Wiper code of channel 1 |

## Verification
The assertions assume `stop_evt` is a single-cycle pulse. They also assume every write beat lasts exactly one cycle, so one bus transaction puts at most one beat between two STOP pulses. The bench keeps to this by driving all inputs at the falling clock edge and raising each strobe for one cycle only. It offers beats during busy only to show that they are refused. Expected values come from a model of the mode byte and the stored bytes kept in the bench's own vectors.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned NV_BYTES = 8;
  localparam int unsigned GP_LO    = 2;
  localparam int unsigned GP_HI    = 6;
  localparam int unsigned RSV_ADDR = 7;
  localparam int unsigned MODE_ADDR = 8;

  typedef enum logic [1:0] {
    SEQ_RECALL = 2'd0,
    SEQ_IDLE   = 2'd1,
    SEQ_COMMIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/wrb_seq.sv
module wrb_seq
  import wrb_pkg::*;
#(
  parameter int unsigned NV_CYC     = 2400000,
  parameter int unsigned RECALL_CYC = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_evt,
  input  logic nv_pend,
  output logic busy,
  output logic recall_go,
  output logic commit_go
);
  localparam int unsigned MAXC = (NV_CYC > RECALL_CYC) ? NV_CYC : RECALL_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  seq_state_e     state;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_RECALL;
      cnt   <= CW'(RECALL_CYC - 1);
    end else begin
      unique case (state)
        SEQ_RECALL: begin
          if (cnt == '0) state <= SEQ_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        SEQ_IDLE: begin
          if (stop_evt && nv_pend) begin
            state <= SEQ_COMMIT;
            cnt   <= CW'(NV_CYC - 1);
          end
        end
        SEQ_COMMIT: begin
          if (cnt == '0) state <= SEQ_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SEQ_IDLE);
  assign recall_go = (state == SEQ_RECALL) && (cnt == '0);
  assign commit_go = (state == SEQ_COMMIT) && (cnt == '0);

  // A pending write plus STOP while idle must open a busy cycle
  assert_commit_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_evt && nv_pend) |=> busy);

  // Idle stays idle unless a STOP meets a pending write
  assert_quiet_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(stop_evt && nv_pend)) |=> !busy);
endmodule

// File: rtl/wrb_nv_array.sv
module wrb_nv_array
  import wrb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [NUM_CH-1:0][DATA_W-1:0] IVR_INIT = '{default: 8'h80},
  localparam int unsigned AW = $clog2(NV_BYTES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [AW-1:0]                    waddr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NV_BYTES-1:0][DATA_W-1:0]  bytes_q
);
  for (genvar i = 0; i < NV_BYTES; i++) begin : g_byte
    if (i < NUM_CH) begin : g_ivr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       bytes_q[i] <= IVR_INIT[i];
        else if (we && waddr == AW'(i))   bytes_q[i] <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       bytes_q[i] <= '0;
        else if (we && waddr == AW'(i))   bytes_q[i] <= wdata;
      end
    end
  end

  // Stored bytes only move on a commit strobe from the sequencer
  assert_nv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bytes_q));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wrb_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NV_CYC     = 2400000,
  parameter int unsigned RECALL_CYC = 600000,
  parameter logic [DATA_W-1:0] IVR0_INIT = 8'h80,
  parameter logic [DATA_W-1:0] IVR1_INIT = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stop_evt,
  output logic              busy,
  output logic [DATA_W-1:0] wiper0,
  output logic [DATA_W-1:0] wiper1
);
  localparam int unsigned NVA_W = $clog2(NV_BYTES);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic                            recall_go, commit_go;
  logic [NV_BYTES-1:0][DATA_W-1:0] nv_q;
  logic [NUM_CH-1:0][DATA_W-1:0]   wip_q;
  logic [DATA_W-1:0]               mode_q;
  logic                            pend_q;
  logic [NVA_W-1:0]                paddr_q;
  logic [DATA_W-1:0]               pdata_q;

  logic wr_fire, w_is_ch, w_is_gp, w_is_mode, mode_open, nv_req, mode_legal;

  assign wr_ready   = !busy;
  assign wr_fire    = wr_valid && wr_ready;
  assign mode_open  = (mode_q == '0);
  assign w_is_ch    = wr_addr < ADDR_W'(NUM_CH);
  assign w_is_gp    = (wr_addr >= ADDR_W'(GP_LO)) && (wr_addr <= ADDR_W'(GP_HI));
  assign w_is_mode  = wr_addr == ADDR_W'(MODE_ADDR);
  assign mode_legal = (wr_data == '0) || (wr_data == MID);
  assign nv_req     = (w_is_ch || w_is_gp) && mode_open;

  wrb_seq #(.NV_CYC(NV_CYC), .RECALL_CYC(RECALL_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .nv_pend(pend_q),
    .busy(busy), .recall_go(recall_go), .commit_go(commit_go)
  );

  wrb_nv_array #(.DATA_W(DATA_W), .IVR_INIT({IVR1_INIT, IVR0_INIT})) nv_i (
    .clk(clk), .rst_n(rst_n), .we(commit_go), .waddr(paddr_q),
    .wdata(pdata_q), .bytes_q(nv_q)
  );

  // Pending commit: latest accepted beat decides, STOP consumes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else if (wr_fire) begin
      pend_q  <= nv_req;
      paddr_q <= wr_addr[NVA_W-1:0];
      pdata_q <= wr_data;
    end else if (stop_evt && !busy) begin
      pend_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                mode_q <= '0;
    else if (wr_fire && w_is_mode && mode_legal) mode_q <= wr_data;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    wip_q[c] <= MID;
      else if (recall_go)                            wip_q[c] <= nv_q[c];
      else if (wr_fire && wr_addr == ADDR_W'(c))     wip_q[c] <= wr_data;
    end
  end

  assign wiper0 = wip_q[0];
  assign wiper1 = wip_q[1];

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NUM_CH)) begin
      rd_data = mode_open ? nv_q[rd_addr[NVA_W-1:0]] : wip_q[rd_addr[0]];
    end else if (rd_addr >= ADDR_W'(GP_LO) && rd_addr <= ADDR_W'(GP_HI)) begin
      rd_data = mode_open ? nv_q[rd_addr[NVA_W-1:0]] : '0;
    end else if (rd_addr == ADDR_W'(MODE_ADDR)) begin
      rd_data = mode_q;
    end
  end

  assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == '0) || (mode_q == MID));

  assert_mode_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && w_is_mode && !mode_legal) |=> $stable(mode_q));

  assert_wiper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !recall_go) |=> $stable(wip_q));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid) |=> $stable(wip_q) && $stable(mode_q));
endmodule

// File: tb/wiper_bank_tb_top.sv
module wiper_bank_tb_top;
  localparam int unsigned NV_CYC = 40;
  localparam int unsigned RC_CYC = 16;
  localparam logic [7:0] IV0 = 8'h3C;
  localparam logic [7:0] IV1 = 8'hC5;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SNV = 2'd2, OP_SQ = 2'd3;
  localparam int NV = 19;
  // {req[3:0], op[1:0], addr[7:0], data[7:0], exp[7:0]}
  localparam logic [29:0] VEC [NV] = '{
    {4'd3, OP_RD,  8'h00, 8'h00, 8'h3C},  // R3 stored value 0
    {4'd3, OP_RD,  8'h01, 8'h00, 8'hC5},  // R3 stored value 1
    {4'd5, OP_WR,  8'h02, 8'hA5, 8'h00},  // R5 gp write, mode 00
    {4'd6, OP_SNV, 8'h00, 8'h00, 8'h00},  // R6 commit
    {4'd6, OP_RD,  8'h02, 8'h00, 8'hA5},  // R6 committed byte
    {4'd8, OP_WR,  8'h08, 8'h80, 8'h00},  // R8 mode 80
    {4'd8, OP_RD,  8'h08, 8'h00, 8'h80},  // R8
    {4'd5, OP_RD,  8'h02, 8'h00, 8'h00},  // R5 gp hidden
    {4'd5, OP_WR,  8'h03, 8'h77, 8'h00},  // R5 discarded
    {4'd7, OP_SQ,  8'h00, 8'h00, 8'h00},  // R7 no commit
    {4'd8, OP_WR,  8'h08, 8'h00, 8'h00},  // R8 mode 00
    {4'd5, OP_RD,  8'h03, 8'h00, 8'h00},  // R5 still 00
    {4'd8, OP_WR,  8'h08, 8'h55, 8'h00},  // R8 illegal value
    {4'd8, OP_RD,  8'h08, 8'h00, 8'h00},  // R8 unchanged
    {4'd9, OP_WR,  8'h07, 8'h11, 8'h00},  // R9 reserved write
    {4'd9, OP_SQ,  8'h00, 8'h00, 8'h00},  // R9 no commit
    {4'd9, OP_RD,  8'h07, 8'h00, 8'h00},  // R9
    {4'd9, OP_RD,  8'h09, 8'h00, 8'h00},  // R9
    {4'd9, OP_RD,  8'hFF, 8'h00, 8'h00}   // R9
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, stop_evt = 1'b0, wr_ready, busy;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data, wiper0, wiper1;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wiper_bank #(.NV_CYC(NV_CYC), .RECALL_CYC(RC_CYC), .IVR0_INIT(IV0), .IVR1_INIT(IV1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stop_evt(stop_evt), .busy(busy), .wiper0(wiper0), .wiper1(wiper1)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic do_rd(input string tag, input logic [7:0] a, input logic [7:0] e);
    @(negedge clk); rd_addr = a; #1;
    chk(tag, rd_data, e);
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 wiper0", wiper0, 8'h80);
    chk("R1 wiper1", wiper1, 8'h80);
    chk("R1 busy", busy, 1);
    chk("R1 wr_ready", wr_ready, 0);
    rst_n = 1'b1;
    busy_len(n);
    chk("R2 recall length", n, RC_CYC);
    chk("R2 wiper0 recalled", wiper0, IV0);
    chk("R2 wiper1 recalled", wiper1, IV1);

    for (int i = 0; i < NV; i++) begin
      automatic logic [3:0] rq = VEC[i][29:26];
      automatic logic [1:0] op = VEC[i][25:24];
      automatic logic [7:0] a = VEC[i][23:16], d = VEC[i][15:8], e = VEC[i][7:0];
      automatic string tag = $sformatf("R%0d vec%0d", rq, i);
      case (op)
        OP_WR:  do_wr(a, d);
        OP_RD:  do_rd(tag, a, e);
        OP_SNV: begin pulse_stop(); busy_len(n); chk(tag, n, NV_CYC); end
        default: begin
          pulse_stop();
          repeat (3) begin chk(tag, busy, 0); @(negedge clk); end
        end
      endcase
    end

    // R3: mode 00 write to channel 0
    do_wr(8'h00, 8'h11);
    chk("R3 wiper0 immediate", wiper0, 8'h11);
    do_rd("R3 stored before commit", 8'h00, 8'h3C);
    pulse_stop(); busy_len(n);
    chk("R6 commit length", n, NV_CYC);
    do_rd("R3 stored after commit", 8'h00, 8'h11);

    // R4: mode 80 write to channel 1
    do_wr(8'h08, 8'h80);
    do_wr(8'h01, 8'h9A);
    chk("R4 wiper1", wiper1, 8'h9A);
    do_rd("R4 read wiper", 8'h01, 8'h9A);
    pulse_stop();
    chk("R7 no busy after mode80 write", busy, 0);
    do_wr(8'h08, 8'h00);
    do_rd("R4 stored kept", 8'h01, 8'hC5);

    // R10: beats and STOP during busy
    do_wr(8'h02, 8'h42);
    pulse_stop();
    chk("R10 wr_ready low", wr_ready, 0);
    do_wr(8'h01, 8'hEE);
    chk("R10 wiper1 kept", wiper1, 8'h9A);
    pulse_stop();
    busy_len(n);
    repeat (3) @(negedge clk);
    chk("R10 no second commit", busy, 0);
    do_rd("R10 stored byte", 8'h02, 8'h42);
    do_rd("R10 stored ch1", 8'h01, 8'hC5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule